// File: doc/BRIEF.md
# Buffered Synchronous Serial Receiver

This block shifts serial data into a shift register in step with a serial clock and assembles it into words of either 4 or 8 bits, least significant bit first. Each finished word goes into the next slot of a small receive buffer. Once the programmed number of words has arrived, the block raises a one-cycle buffer-full interrupt and resets the read pointer to slot 0. Software then reads the words back in slot order with one read strobe per word.

The serial clock can come from one of two places. It can be generated inside the block from a divider of the system clock and driven out on `sck_out`. Or it can be taken from the `sck_in` pin through a two-flop synchroniser with rising-edge detection.

The two clock sources treat unread data differently. With the internal clock, the block holds its clock high at the next word boundary until one word has been read. With the external clock, a word that completes while the buffer is still unread is dropped, and reception is cancelled.

Reception can end in two ways. Lowering `start` is a graceful stop: the word in progress completes first. Raising `inhibit` ends reception at once and discards the partial word. Changing the word size or the clock source wipes the buffer.

Top module: `srx_receiver`

## Requirements
- R1: After reset, `busy` and `irq` are 0, `sck_out` is 1 and `rd_data` is 0.
- R2: Reception starts on a 0-to-1 change of `start`. `busy` is 1 at the first clock edge after `start` is seen high.
- R3: When `word8`=1, each word is 8 bits received LSB first. The words are stored in successive slots and read back from slot 0 upward, one word per `rd_en` cycle.
- R4: When `word8`=0, each word is 4 bits received LSB first. It is read as a byte with the upper nibble zero.
- R5: `irq` is a single-cycle pulse. It fires when `word_cnt`+1 words have been stored (the 3-bit field encodes 1 to 8 words). At that point the read pointer returns to slot 0.
- R6: In internal mode (`ext_clk`=0), `sck_out` idles high and has a period of 2*HALF system clocks. Data is sampled on its rising edge.
- R7: In internal mode, after a buffer-full event with no read, `sck_out` stays high at the next word boundary and `busy` stays 1. A single `rd_en` releases the clock.
- R8: In external mode (`ext_clk`=1), bits are sampled on rising edges of `sck_in` after synchronisation, and `sck_out` stays high.
- R9: In external mode, a word that completes while the buffer is still full is not stored. `busy` then drops, and no `irq` is raised.
- R10: Lowering `start` mid-word keeps `busy` high until the word's last bit is received. That word is stored, and `busy` is 0 in the cycle its store completes.
- R11: While `inhibit` is 1, `busy` is 0 one clock later. The partial word is discarded and no `irq` is raised.
- R12: Changing `word8` or `ext_clk` clears every buffer slot to 0 and clears the full condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Receive enable; a rising change starts reception, a low level requests a graceful stop |
| inhibit | input | 1 | Immediate abort of reception |
| word8 | input | 1 | 1 selects 8-bit words, 0 selects 4-bit words |
| ext_clk | input | 1 | 1 selects the external serial clock, 0 selects the internal one |
| word_cnt | input | 3 | Words per buffer-full event, minus one |
| sck_in | input | 1 | External serial clock |
| sd_in | input | 1 | Serial data input |
| sck_out | output | 1 | Internally generated serial clock, idles high |
| busy | output | 1 | Reception in progress |
| irq | output | 1 | Buffer-full pulse |
| rd_en | input | 1 | Read strobe; advances the read pointer and releases the full condition |
| rd_data | output | 8 | Word at the current read slot |

## Verification
The hardest states to reach are the two overrun outcomes: the held clock in internal mode and the cancellation in external mode. Both require the buffer to stay unread across a word boundary.

The scoreboard monitor normally drains the buffer as soon as `irq` appears. The stimulus therefore sets a hold flag that stops the monitor from reading. It then queues more serial bits than the programmed word count.

For the internal case, the bench then watches `sck_out` stay high and confirms that no queued bit is consumed. For the external case, it keeps toggling `sck_in` through the whole extra word and confirms that `busy` has fallen and that slot 0 still holds the first word.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} sck_src_e;

   function automatic int unsigned frame_bits(input logic wide, input int unsigned w);
      return wide ? w : w / 2;
   endfunction
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
   parameter int unsigned HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sck,
   output logic tick
);
   localparam int unsigned CNTW = (HALF > 1) ? $clog2(HALF) : 1;

   if (HALF < 2) begin : g_bad_half
      $error("srx_clkgen: HALF must be at least 2");
   end

   logic [CNTW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sck  <= 1'b1;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (!en) begin
            cnt <= '0;
            sck <= 1'b1;
         end else if (cnt == CNTW'(HALF - 1)) begin
            cnt  <= '0;
            sck  <= ~sck;
            tick <= ~sck;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R6: clock parks high whenever it is not enabled
   a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> sck);
   // R6: sampling strobe follows a rising edge of the serial clock
   a_r6_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (sck && !$past(sck)));
endmodule

// File: rtl/srx_extsync.sv
module srx_extsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_pin,
   input  logic sd_pin,
   output logic tick,
   output logic sd
);
   if (STAGES < 2) begin : g_bad_stages
      $error("srx_extsync: STAGES must be at least 2");
   end

   logic [STAGES:0]   ck_sh;
   logic [STAGES-1:0] sd_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_sh <= '1;
         sd_sh <= '0;
      end else begin
         ck_sh <= {ck_sh[STAGES-1:0], sck_pin};
         sd_sh <= {sd_sh[STAGES-2:0], sd_pin};
      end
   end

   assign tick = ck_sh[STAGES-1] & ~ck_sh[STAGES];
   assign sd   = sd_sh[STAGES-1];

   // R8: one strobe per synchronised rising edge
   a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/srx_core.sv
module srx_core
   import srx_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         inhibit,
   input  logic         wide,
   input  logic         ext,
   input  logic         tick,
   input  logic         sd,
   input  logic         full,
   output logic         busy,
   output logic         at_boundary,
   output logic         begin_rx,
   output logic         wr_en,
   output logic [W-1:0] wr_data
);
   localparam int unsigned BW = $clog2(W);

   if (W < 4 || (W % 2) != 0) begin : g_bad_w
      $error("srx_core: W must be even and at least 4");
   end

   logic         start_q;
   logic [W-1:0] sr, sr_nx;
   logic [BW-1:0] bit_idx;
   logic         last;
   logic         src_ext;

   assign src_ext     = (sck_src_e'(ext) == SRC_EXT);
   assign sr_nx       = {sd, sr[W-1:1]};
   assign last        = (bit_idx == BW'(frame_bits(wide, W) - 1));
   assign at_boundary = (bit_idx == '0);
   assign begin_rx    = start & ~start_q & ~busy & ~inhibit;
   assign wr_en       = busy & tick & last & ~full;
   assign wr_data     = wide ? sr_nx : (sr_nx >> (W / 2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         busy    <= 1'b0;
         bit_idx <= '0;
         sr      <= '0;
      end else begin
         start_q <= start;
         if (inhibit) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            sr      <= '0;
         end else if (begin_rx) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            sr      <= '0;
         end else if (busy) begin
            if (tick) begin
               sr <= sr_nx;
               if (last) begin
                  bit_idx <= '0;
                  if ((src_ext && full) || !start) busy <= 1'b0;
               end else begin
                  bit_idx <= bit_idx + 1'b1;
               end
            end else if (at_boundary && !start) begin
               busy <= 1'b0;
            end
         end
      end
   end

   // R11: abort takes effect on the next edge
   a_r11_inhibit_stops: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |=> !busy);
   // R2: a rising start while idle brings up busy
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start) && !busy && !inhibit) |=> busy);
   // R9: word completing on a full buffer in external mode cancels reception
   a_r9_cancel_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && src_ext && full && tick && last && !inhibit) |=> !busy);
   // R10: graceful stop waits for the word in progress
   a_r10_finish_word: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && !inhibit && !tick && !at_boundary) |=> busy);
endmodule

// File: rtl/srx_store.sv
module srx_store #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     restart,
   input  logic                     wr_en,
   input  logic [W-1:0]             wr_data,
   input  logic [$clog2(DEPTH)-1:0] word_cnt,
   input  logic                     rd_en,
   output logic [W-1:0]             rd_data,
   output logic                     full,
   output logic                     irq
);
   localparam int unsigned CW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("srx_store: DEPTH must be a power of two, at least 2");
   end

   logic [CW-1:0]             wr_ptr, rd_ptr;
   logic [DEPTH-1:0][W-1:0]   slots;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           q <= '0;
         else if (clear)                       q <= '0;
         else if (wr_en && wr_ptr == CW'(g))   q <= wr_data;
      end
      assign slots[g] = q;
   end

   assign rd_data = slots[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         full   <= 1'b0;
         irq    <= 1'b0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         full   <= 1'b0;
         irq    <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (restart) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end
         if (rd_en) begin
            rd_ptr <= rd_ptr + 1'b1;
            full   <= 1'b0;
         end
         if (wr_en) begin
            if (wr_ptr >= word_cnt) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               full   <= 1'b1;
               irq    <= 1'b1;
            end else begin
               wr_ptr <= wr_ptr + 1'b1;
            end
         end
      end
   end

   // R5: interrupt lasts one cycle
   a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R5: interrupt comes with a full buffer read from slot 0
   a_r5_irq_slot0: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (full && rd_ptr == '0));
   // R12: clear empties the buffer
   a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!full && rd_data == '0));
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
   parameter int unsigned W      = 8,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned HALF   = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     inhibit,
   input  logic                     word8,
   input  logic                     ext_clk,
   input  logic [$clog2(DEPTH)-1:0] word_cnt,
   input  logic                     sck_in,
   input  logic                     sd_in,
   output logic                     sck_out,
   output logic                     busy,
   output logic                     irq,
   input  logic                     rd_en,
   output logic [W-1:0]             rd_data
);
   logic word8_q, ext_q, clear;
   logic int_tick, ext_tick, ext_sd;
   logic tick, sd, full, at_boundary, begin_rx, wr_en, en_int;
   logic [W-1:0] wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word8_q <= 1'b1;
         ext_q   <= 1'b0;
      end else begin
         word8_q <= word8;
         ext_q   <= ext_clk;
      end
   end

   assign clear  = (word8 != word8_q) | (ext_clk != ext_q);
   assign en_int = busy & ~ext_clk & ~(full & at_boundary);
   assign tick   = ext_clk ? ext_tick : int_tick;
   assign sd     = ext_clk ? ext_sd : sd_in;

   srx_clkgen #(.HALF(HALF)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .en(en_int), .sck(sck_out), .tick(int_tick)
   );

   srx_extsync #(.STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck_pin(sck_in), .sd_pin(sd_in),
      .tick(ext_tick), .sd(ext_sd)
   );

   srx_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .start(start), .inhibit(inhibit),
      .wide(word8), .ext(ext_clk), .tick(tick), .sd(sd), .full(full),
      .busy(busy), .at_boundary(at_boundary), .begin_rx(begin_rx),
      .wr_en(wr_en), .wr_data(wr_data)
   );

   srx_store #(.W(W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clear(clear), .restart(begin_rx),
      .wr_en(wr_en), .wr_data(wr_data), .word_cnt(word_cnt), .rd_en(rd_en),
      .rd_data(rd_data), .full(full), .irq(irq)
   );

   // R7: unread buffer at a word boundary holds the internal clock high
   a_r7_wait_holds_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ext_clk && full && at_boundary) |=> sck_out);
   // R8: the internal clock stays parked in external mode
   a_r8_ext_parks_sck: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_clk && $past(ext_clk)) |-> sck_out);
endmodule

// File: tb/srx_receiver_test.sv
`timescale 1ns/1ps
module srx_receiver_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0, inhibit = 1'b0, word8 = 1'b1, ext_clk = 1'b0;
   logic [2:0] word_cnt = 3'd0;
   logic       sck_in = 1'b1, sd_in = 1'b0, rd_en = 1'b0;
   logic       sck_out, busy, irq;
   logic [7:0] rd_data;

   int checks = 0, errors = 0;
   int irq_cnt = 0, pend = 0;
   bit hold_reads = 0, flush = 0, ext_run = 0, done = 0;
   string cur_req = "R3";
   logic [7:0] expq[$];
   bit         bitq[$];

   always #2.5 clk = ~clk;

   srx_receiver uut (
      .clk(clk), .rst_n(rst_n), .start(start), .inhibit(inhibit),
      .word8(word8), .ext_clk(ext_clk), .word_cnt(word_cnt),
      .sck_in(sck_in), .sd_in(sd_in), .sck_out(sck_out), .busy(busy),
      .irq(irq), .rd_en(rd_en), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_bits(input logic [7:0] v);
      for (int i = 0; i < (word8 ? 8 : 4); i++) bitq.push_back(v[i]);
   endtask

   task automatic push_word(input logic [7:0] v);
      expq.push_back(word8 ? v : {4'h0, v[3:0]});
      push_bits(v);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_drained();
      while (bitq.size() != 0) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic run_int();
      @(negedge clk); start = 1'b1;
      wait_drained();
      start = 1'b0;
      wait_idle();
      cycles(4);
   endtask

   // serial feeder: the only driver of sd_in and sck_in
   initial begin
      bit prev = 1'b1;
      forever begin
         @(negedge clk);
         if (!ext_clk) begin
            if (prev && !sck_out) sd_in = (bitq.size() != 0) ? bitq.pop_front() : 1'b0;
            prev = sck_out;
         end else if (ext_run && bitq.size() != 0) begin
            sd_in = bitq.pop_front();
            sck_in = 1'b0;
            repeat (6) @(negedge clk);
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
         end
      end
   end

   // scoreboard monitor: the only driver of rd_en
   initial begin
      bit irq_prev = 1'b0;
      forever begin
         @(negedge clk);
         if (flush) begin
            pend = 0;
            expq.delete();
         end
         if (irq_prev && irq) chk(1'b0, "R5 irq longer than one cycle", 1, 0);
         irq_prev = irq;
         if (irq) begin
            irq_cnt++;
            pend += int'(word_cnt) + 1;
         end
         if (pend > 0 && !hold_reads && !flush) begin
            if (expq.size() != 0) begin
               logic [7:0] e;
               e = expq.pop_front();
               chk(rd_data == e, cur_req, rd_data, e);
            end else begin
               chk(1'b0, {cur_req, " unexpected word"}, rd_data, 0);
            end
            rd_en = 1'b1;
            pend--;
         end else begin
            rd_en = 1'b0;
         end
      end
   end

   initial begin
      int n0;
      int bad;
      realtime t1, t2;
      cycles(3);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(sck_out == 1'b1, "R1 sck_out", sck_out, 1);
      chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
      rst_n = 1'b1;
      cycles(3);

      // R2, R3, R5, R6: internal clock, 8-bit, three words
      cur_req = "R3";
      word_cnt = 3'd2;
      n0 = irq_cnt;
      push_word(8'hA5); push_word(8'h3C); push_word(8'h81);
      chk(busy == 1'b0, "R2 idle before start", busy, 0);
      @(negedge clk); start = 1'b1;
      chk(busy == 1'b0, "R2 busy not yet", busy, 0);
      @(negedge clk);
      chk(busy == 1'b1, "R2 busy after one edge", busy, 1);
      @(posedge sck_out); t1 = $realtime;
      @(posedge sck_out); t2 = $realtime;
      chk((t2 - t1) > 39.9 && (t2 - t1) < 40.1, "R6 sck period ns", int'(t2 - t1), 40);
      wait_drained();
      start = 1'b0;
      wait_idle();
      cycles(6);
      chk(irq_cnt == n0 + 1, "R5 one irq for three words", irq_cnt - n0, 1);
      chk(expq.size() == 0, "R3 all words read", expq.size(), 0);

      // R4: 4-bit words, four per event
      cur_req = "R4";
      word8 = 1'b0; word_cnt = 3'd3;
      cycles(2);
      n0 = irq_cnt;
      push_word(8'h09); push_word(8'h06); push_word(8'h0F); push_word(8'h01);
      run_int();
      cycles(4);
      chk(irq_cnt == n0 + 1, "R4 one irq for four nibbles", irq_cnt - n0, 1);
      chk(expq.size() == 0, "R4 all nibbles read", expq.size(), 0);

      // R7: auto-wait with internal clock
      cur_req = "R7";
      word8 = 1'b1; word_cnt = 3'd0;
      cycles(2);
      hold_reads = 1;
      n0 = irq_cnt;
      push_word(8'hE1); push_word(8'h2D);
      @(negedge clk); start = 1'b1;
      while (irq_cnt == n0) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (sck_out !== 1'b1) bad++;
      end
      chk(bad == 0, "R7 sck held high", bad, 0);
      chk(busy == 1'b1, "R7 busy during wait", busy, 1);
      chk(bitq.size() == 8, "R7 no bits consumed in wait", bitq.size(), 8);
      hold_reads = 0;
      wait_drained();
      start = 1'b0;
      wait_idle();
      cycles(6);
      chk(irq_cnt == n0 + 2, "R7 second word after release", irq_cnt - n0, 2);
      chk(expq.size() == 0, "R7 both words read", expq.size(), 0);

      // R10: graceful stop mid-word
      cur_req = "R10";
      n0 = irq_cnt;
      push_word(8'h5A);
      @(negedge clk); start = 1'b1;
      while (bitq.size() > 5) @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R10 busy kept mid-word", busy, 1);
      while (!irq) @(negedge clk);
      chk(busy == 1'b0, "R10 busy low at store", busy, 0);
      cycles(4);
      chk(irq_cnt == n0 + 1, "R10 final word stored", irq_cnt - n0, 1);

      // R11: inhibit discards the partial word
      cur_req = "R11";
      n0 = irq_cnt;
      push_bits(8'hFF);
      @(negedge clk); start = 1'b1;
      while (bitq.size() > 5) @(negedge clk);
      inhibit = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R11 busy drops", busy, 0);
      @(negedge clk);
      chk(sck_out == 1'b1, "R11 sck parked", sck_out, 1);
      bitq.delete();
      start = 1'b0;
      cycles(4);
      inhibit = 1'b0;
      chk(irq_cnt == n0, "R11 no irq", irq_cnt - n0, 0);
      push_word(8'h96);
      run_int();
      cycles(4);
      chk(irq_cnt == n0 + 1, "R11 clean word after abort", irq_cnt - n0, 1);

      // R12: mode change clears the buffer
      cur_req = "R12";
      word_cnt = 3'd1;
      hold_reads = 1;
      push_word(8'h11); push_word(8'h22);
      run_int();
      chk(rd_data == 8'h11, "R12 slot 0 before clear", rd_data, 8'h11);
      word8 = 1'b0;
      cycles(2);
      chk(rd_data == 8'h00, "R12 slot cleared", rd_data, 0);
      flush = 1; cycles(2); flush = 0;
      hold_reads = 0;
      word8 = 1'b1;
      cycles(2);

      // R8: external clock, two words
      cur_req = "R8";
      ext_clk = 1'b1;
      cycles(3);
      n0 = irq_cnt;
      push_word(8'hC3); push_word(8'h7E);
      @(negedge clk); start = 1'b1; ext_run = 1;
      wait_drained();
      cycles(20);
      start = 1'b0;
      wait_idle();
      cycles(4);
      chk(irq_cnt == n0 + 1, "R8 irq after two words", irq_cnt - n0, 1);
      chk(sck_out == 1'b1, "R8 sck_out parked", sck_out, 1);
      chk(expq.size() == 0, "R8 words read", expq.size(), 0);

      // R9: external overrun cancels
      cur_req = "R9";
      word_cnt = 3'd0;
      hold_reads = 1;
      n0 = irq_cnt;
      push_word(8'h42);
      push_bits(8'h99);
      @(negedge clk); start = 1'b1;
      wait_drained();
      cycles(20);
      chk(busy == 1'b0, "R9 reception cancelled", busy, 0);
      chk(irq_cnt == n0 + 1, "R9 no second irq", irq_cnt - n0, 1);
      chk(rd_data == 8'h42, "R9 slot 0 kept", rd_data, 8'h42);
      hold_reads = 0;
      cycles(4);
      start = 1'b0;
      ext_run = 0;
      chk(expq.size() == 0, "R9 first word read", expq.size(), 0);

      cycles(5);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule